// File: doc/BRIEF.md
# DC Link Voltage Fault Monitor

This block watches samples of a DC link: the total link voltage and the voltage seen at each of two power modules. It compares them against limits that change with the machine phase, which is either the startup phase (precharge through resistors) or normal operation. When a limit is crossed it reports a coded fault and requests a machine stop. An overvoltage also drops the relay that bypasses the charging resistors, so those resistors are placed back in series with the supply.

A fault code is a 16-bit word: the upper byte is the fault group and the lower byte is the subcode. Overvoltage and undervoltage faults are latched until software clears them. A module imbalance fault follows the most recent valid sample and clears itself. The bypass relay closes when startup ends with enough voltage on the link. All voltages are unsigned whole volts.

Top module: `bus_guard`

## Requirements
- R1: In the startup phase (`phase_run`=0), a valid sample with `v_total` > 700 latches overvoltage code 0x0202 (group 2, subcode 2). It is visible on `fault_code` one clock after the sample.
- R2: In the operation phase (`phase_run`=1), a valid sample with `v_total` > 750 latches overvoltage code 0x0204.
- R3: In either phase, a valid sample with `v_mod_a` > 400 or `v_mod_b` > 400 latches overvoltage code 0x0205.
- R4: While any overvoltage is latched, `relay_closed` is 0. It stays 0 after the fault is cleared until a later successful end of startup (R6).
- R5: On a `start_done` pulse, if the most recent total sample is below 390, undervoltage code 0x1603 (group 22, subcode 3) is latched. The most recent sample is the one in the same cycle if `smp_vld` is high, otherwise the last valid one, or 0 after reset.
- R6: A `start_done` pulse whose most recent total sample is 390 or more, with no overvoltage latched or being raised, sets `relay_closed` to 1 from the next clock.
- R7: A valid sample with |`v_mod_a` − `v_mod_b`| > 60 raises imbalance code 0x2101 in the operation phase and 0x2102 in the startup phase.
- R8: The imbalance fault is cleared by the next valid sample whose module difference is 60 or less. Cycles without `smp_vld` leave it unchanged.
- R9: Latched overvoltage and undervoltage faults are removed only by `flt_clr`. If the set condition is present in the same cycle as `flt_clr`, the fault stays latched.
- R10: Reported priority is 0x0202, 0x0204, 0x0205, 0x1603, then imbalance. `fault_code` is 0 with no fault. `stop_req` is 1 exactly when `fault_code` is nonzero.
- R11: Without `smp_vld`, voltage inputs are ignored: no fault is set, and the imbalance state does not change.
- R12: Synchronous reset gives `fault_code`=0, `stop_req`=0 and `relay_closed`=0, and clears the stored total sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Voltage samples valid this cycle |
| v_total | input | VW | Total link voltage, volts |
| v_mod_a | input | VW | Module A link voltage, volts |
| v_mod_b | input | VW | Module B link voltage, volts |
| phase_run | input | 1 | 0 = startup phase, 1 = operation phase |
| start_done | input | 1 | One-cycle pulse marking the end of startup |
| flt_clr | input | 1 | Clear request for latched faults |
| fault_code | output | 16 | Highest-priority active code, {group, subcode} |
| stop_req | output | 1 | Machine stop request |
| relay_closed | output | 1 | 1 = bypass relay closed (charging resistors shorted) |

## Verification
Several functions can act in the same cycle. A clear can land on the same edge as a fresh overvoltage or undervoltage condition. The bench provokes this by asserting `flt_clr` together with an over-limit sample, and together with a low-voltage `start_done`, and expects the fault to remain latched. A second overlap is between faults of different priority: overvoltage, undervoltage and imbalance are raised together so that only the arbitration decides which code is shown. A third is an end-of-startup pulse on the same cycle as an overvoltage sample, which must leave the relay open. Every outcome is compared with a cycle model computed in the bench.

// File: rtl/bus_guard_pkg.sv
package bus_guard_pkg;

    localparam logic [7:0] GRP_OVER  = 8'd2;
    localparam logic [7:0] GRP_UNDER = 8'd22;
    localparam logic [7:0] GRP_IMBAL = 8'd33;

    typedef struct packed {
        logic [7:0] group;
        logic [7:0] sub;
    } fault_code_t;

    // set events produced by the comparator stage for one cycle
    typedef struct packed {
        logic ov_start;
        logic ov_run;
        logic ov_mod;
        logic uv;
        logic start_ok;
        logic imb_upd;
        logic imb;
        logic imb_start;
    } fault_evt_t;

    // held fault state
    typedef struct packed {
        logic ov_start;
        logic ov_run;
        logic ov_mod;
        logic uv;
        logic imb;
        logic imb_start;
    } fault_state_t;

    function automatic fault_code_t code_of(input fault_state_t s);
        fault_code_t c;
        if (s.ov_start)      c = '{GRP_OVER,  8'd2};
        else if (s.ov_run)   c = '{GRP_OVER,  8'd4};
        else if (s.ov_mod)   c = '{GRP_OVER,  8'd5};
        else if (s.uv)       c = '{GRP_UNDER, 8'd3};
        else if (s.imb)      c = '{GRP_IMBAL, s.imb_start ? 8'd2 : 8'd1};
        else                 c = '{8'd0, 8'd0};
        return c;
    endfunction

endpackage

// File: rtl/bus_guard_cmp.sv
module bus_guard_cmp
    import bus_guard_pkg::*;
#(
    parameter int unsigned VW            = 10,
    parameter int unsigned OV_START_LIM  = 700,
    parameter int unsigned OV_RUN_LIM    = 750,
    parameter int unsigned OV_MOD_LIM    = 400,
    parameter int unsigned UV_MIN        = 390,
    parameter int unsigned IMB_LIM       = 60
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          smp_vld,
    input  logic [VW-1:0] v_total,
    input  logic [VW-1:0] v_mod_a,
    input  logic [VW-1:0] v_mod_b,
    input  logic          phase_run,
    input  logic          start_done,
    output fault_evt_t    evt
);
    localparam logic [VW-1:0] L_OV_START = VW'(OV_START_LIM);
    localparam logic [VW-1:0] L_OV_RUN   = VW'(OV_RUN_LIM);
    localparam logic [VW-1:0] L_OV_MOD   = VW'(OV_MOD_LIM);
    localparam logic [VW-1:0] L_UV       = VW'(UV_MIN);
    localparam logic [VW-1:0] L_IMB      = VW'(IMB_LIM);

    logic [VW-1:0] last_total;
    logic [VW-1:0] cur_total;
    logic [VW-1:0] mod_diff;

    always_ff @(posedge clk) begin
        if (rst)          last_total <= '0;
        else if (smp_vld) last_total <= v_total;
    end

    assign cur_total = smp_vld ? v_total : last_total;
    assign mod_diff  = (v_mod_a >= v_mod_b) ? (v_mod_a - v_mod_b) : (v_mod_b - v_mod_a);

    always_comb begin
        evt           = '0;
        evt.ov_start  = smp_vld && !phase_run && (v_total > L_OV_START);
        evt.ov_run    = smp_vld &&  phase_run && (v_total > L_OV_RUN);
        evt.ov_mod    = smp_vld && ((v_mod_a > L_OV_MOD) || (v_mod_b > L_OV_MOD));
        evt.uv        = start_done && (cur_total < L_UV);
        evt.start_ok  = start_done && (cur_total >= L_UV);
        evt.imb_upd   = smp_vld;
        evt.imb       = mod_diff > L_IMB;
        evt.imb_start = !phase_run;
    end

endmodule

// File: rtl/bus_guard_state.sv
module bus_guard_state
    import bus_guard_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         flt_clr,
    input  fault_evt_t   evt,
    output fault_state_t st,
    output logic         relay_on
);
    fault_state_t st_n;
    logic         ov_any_n;
    logic         relay_n;

    always_comb begin
        st_n          = st;
        st_n.ov_start = evt.ov_start | (st.ov_start & ~flt_clr);
        st_n.ov_run   = evt.ov_run   | (st.ov_run   & ~flt_clr);
        st_n.ov_mod   = evt.ov_mod   | (st.ov_mod   & ~flt_clr);
        st_n.uv       = evt.uv       | (st.uv       & ~flt_clr);
        if (evt.imb_upd) begin
            st_n.imb       = evt.imb;
            st_n.imb_start = evt.imb & evt.imb_start;
        end
        ov_any_n = st_n.ov_start | st_n.ov_run | st_n.ov_mod;
        relay_n  = ~ov_any_n & (relay_on | evt.start_ok);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= '0;
            relay_on <= 1'b0;
        end else begin
            st       <= st_n;
            relay_on <= relay_n;
        end
    end

endmodule

// File: rtl/bus_guard_enc.sv
module bus_guard_enc
    import bus_guard_pkg::*;
(
    input  fault_state_t st,
    output fault_code_t  code,
    output logic         any
);
    assign code = code_of(st);
    assign any  = |{st.ov_start, st.ov_run, st.ov_mod, st.uv, st.imb};
endmodule

// File: rtl/bus_guard.sv
module bus_guard
    import bus_guard_pkg::*;
#(
    parameter int unsigned VW            = 10,
    parameter int unsigned OV_START_LIM  = 700,
    parameter int unsigned OV_RUN_LIM    = 750,
    parameter int unsigned OV_MOD_LIM    = 400,
    parameter int unsigned UV_MIN        = 390,
    parameter int unsigned IMB_LIM       = 60
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          smp_vld,
    input  logic [VW-1:0] v_total,
    input  logic [VW-1:0] v_mod_a,
    input  logic [VW-1:0] v_mod_b,
    input  logic          phase_run,
    input  logic          start_done,
    input  logic          flt_clr,
    output logic [15:0]   fault_code,
    output logic          stop_req,
    output logic          relay_closed
);
    fault_evt_t   evt;
    fault_state_t st;
    fault_code_t  code;
    logic         any;
    logic         relay_on;

    bus_guard_cmp #(
        .VW(VW), .OV_START_LIM(OV_START_LIM), .OV_RUN_LIM(OV_RUN_LIM),
        .OV_MOD_LIM(OV_MOD_LIM), .UV_MIN(UV_MIN), .IMB_LIM(IMB_LIM)
    ) u_cmp (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .v_total(v_total),
        .v_mod_a(v_mod_a), .v_mod_b(v_mod_b), .phase_run(phase_run),
        .start_done(start_done), .evt(evt)
    );

    bus_guard_state u_state (
        .clk(clk), .rst(rst), .flt_clr(flt_clr), .evt(evt),
        .st(st), .relay_on(relay_on)
    );

    bus_guard_enc u_enc (
        .st(st), .code(code), .any(any)
    );

    assign fault_code   = code;
    assign stop_req     = any;
    assign relay_closed = relay_on;

endmodule

// File: rtl/bus_guard_chk.sv
module bus_guard_chk #(
    parameter int unsigned VW         = 10,
    parameter int unsigned OV_RUN_LIM = 750,
    parameter int unsigned IMB_LIM    = 60
) (
    input logic          clk,
    input logic          rst,
    input logic          smp_vld,
    input logic [VW-1:0] v_total,
    input logic [VW-1:0] v_mod_a,
    input logic [VW-1:0] v_mod_b,
    input logic          phase_run,
    input logic          start_done,
    input logic          flt_clr,
    input logic [15:0]   fault_code,
    input logic          stop_req,
    input logic          relay_closed
);
    logic [VW-1:0] dif;
    logic          ov_shown;
    assign dif      = (v_mod_a >= v_mod_b) ? (v_mod_a - v_mod_b) : (v_mod_b - v_mod_a);
    assign ov_shown = (fault_code[15:8] == 8'd2);

    assert_reset_state_R12: assert property (@(posedge clk)
        rst |=> (fault_code == 16'd0 && !stop_req && !relay_closed));

    assert_run_overvolt_R2: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && phase_run && (v_total > VW'(OV_RUN_LIM))) |=> ov_shown);

    assert_relay_open_R4: assert property (@(posedge clk) disable iff (rst)
        ov_shown |-> !relay_closed);

    assert_imbalance_stops_R7: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && (dif > VW'(IMB_LIM))) |=> stop_req);

    assert_ov_held_R9: assert property (@(posedge clk) disable iff (rst)
        (ov_shown && !flt_clr) |=> ov_shown);

    assert_idle_stable_R11: assert property (@(posedge clk) disable iff (rst)
        (!smp_vld && !start_done && !flt_clr) |=> $stable(fault_code));

endmodule

bind bus_guard bus_guard_chk #(.VW(VW), .OV_RUN_LIM(OV_RUN_LIM), .IMB_LIM(IMB_LIM)) u_chk (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .v_total(v_total),
    .v_mod_a(v_mod_a), .v_mod_b(v_mod_b), .phase_run(phase_run),
    .start_done(start_done), .flt_clr(flt_clr), .fault_code(fault_code),
    .stop_req(stop_req), .relay_closed(relay_closed)
);

// File: tb/bus_guard_tb.sv
`timescale 1ns/1ps
module bus_guard_tb;
    localparam int VW = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          smp_vld = 1'b0;
    logic [VW-1:0] v_total = '0;
    logic [VW-1:0] v_mod_a = '0;
    logic [VW-1:0] v_mod_b = '0;
    logic          phase_run = 1'b0;
    logic          start_done = 1'b0;
    logic          flt_clr = 1'b0;
    logic [15:0]   fault_code;
    logic          stop_req;
    logic          relay_closed;

    int checks = 0;
    int failures = 0;

    // bench model state
    bit m_ov2, m_ov4, m_ov5, m_uv, m_imb, m_imbs, m_relay;
    int m_last;

    always #2 clk = ~clk;

    bus_guard u_dut (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .v_total(v_total),
        .v_mod_a(v_mod_a), .v_mod_b(v_mod_b), .phase_run(phase_run),
        .start_done(start_done), .flt_clr(flt_clr), .fault_code(fault_code),
        .stop_req(stop_req), .relay_closed(relay_closed)
    );

    function automatic logic [15:0] exp_code();
        if (m_ov2) return 16'h0202;
        if (m_ov4) return 16'h0204;
        if (m_ov5) return 16'h0205;
        if (m_uv)  return 16'h1603;
        if (m_imb) return m_imbs ? 16'h2102 : 16'h2101;
        return 16'h0000;
    endfunction

    task automatic compare(input string tag);
        logic [15:0] ec;
        ec = exp_code();
        checks++;
        if (fault_code !== ec || stop_req !== (ec != 0) || relay_closed !== m_relay) begin
            failures++;
            $display("FAIL %s: code=%h stop=%b relay=%b expected code=%h stop=%b relay=%b",
                     tag, fault_code, stop_req, relay_closed, ec, (ec != 0), m_relay);
        end
    endtask

    task automatic step(input bit vld, input int tot, input int a, input int b,
                        input bit run, input bit done, input bit clr, input string tag);
        int cur, d;
        bit s2, s4, s5, suv, ovany;
        @(negedge clk);
        smp_vld = vld; v_total = VW'(tot); v_mod_a = VW'(a); v_mod_b = VW'(b);
        phase_run = run; start_done = done; flt_clr = clr;
        @(posedge clk);
        cur = vld ? tot : m_last;
        s2  = vld && !run && tot > 700;
        s4  = vld && run && tot > 750;
        s5  = vld && (a > 400 || b > 400);
        suv = done && cur < 390;
        m_ov2 = s2 || (m_ov2 && !clr);
        m_ov4 = s4 || (m_ov4 && !clr);
        m_ov5 = s5 || (m_ov5 && !clr);
        m_uv  = suv || (m_uv && !clr);
        if (vld) begin
            d = (a > b) ? a - b : b - a;
            m_imb  = d > 60;
            m_imbs = m_imb && !run;
            m_last = tot;
        end
        ovany   = m_ov2 || m_ov4 || m_ov5;
        m_relay = !ovany && (m_relay || (done && !suv));
        #1;
        compare(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; smp_vld = 0; start_done = 0; flt_clr = 0;
        @(posedge clk);
        m_ov2 = 0; m_ov4 = 0; m_ov5 = 0; m_uv = 0; m_imb = 0; m_imbs = 0;
        m_relay = 0; m_last = 0;
        #1;
        compare("R12 reset state");
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic idle_clear(input string tag);
        step(0, 0, 0, 0, 0, 0, 1, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        do_reset();

        // R1 / R2: total voltage sweep in both phases
        for (int ph = 0; ph < 2; ph++) begin
            for (int t = 600; t <= 800; t++) begin
                step(1, t, 300, 300, ph[0], 0, 0, ph == 0 ? "R1 startup total sweep" : "R2 run total sweep");
                idle_clear("R9 clear after total sweep");
            end
        end

        // R3 / R7 / R8 / R10: module grid in both phases
        for (int ph = 0; ph < 2; ph++) begin
            for (int a = 0; a <= 460; a += 20) begin
                for (int b = 0; b <= 460; b += 20) begin
                    step(1, 500, a, b, ph[0], 0, 0, "R3 R7 module grid");
                    idle_clear("R8 imbalance unchanged without sample");
                end
            end
        end
        step(1, 500, 100, 161, 1, 0, 0, "R7 difference 61 run");
        step(1, 500, 100, 160, 1, 0, 0, "R8 difference 60 clears");
        step(1, 500, 161, 100, 0, 0, 0, "R7 difference 61 startup");
        step(0, 500, 0, 0, 0, 0, 0, "R8 held without sample");
        step(1, 500, 200, 200, 0, 0, 0, "R8 equal modules clear");

        // R5 / R6: end of startup around the minimum
        for (int t = 370; t <= 410; t++) begin
            step(1, t, 300, 300, 0, 0, 0, "R5 prime sample");
            step(0, 0, 0, 0, 0, 1, 0, "R5 R6 start_done on stored sample");
            do_reset();
        end
        step(1, 389, 300, 300, 0, 1, 0, "R5 same-cycle sample 389");
        idle_clear("R9 clear undervoltage");
        step(1, 390, 300, 300, 0, 1, 0, "R6 same-cycle sample 390");

        // R4: overvoltage opens relay, stays open after clear
        step(1, 760, 300, 300, 1, 0, 0, "R4 overvoltage opens relay");
        idle_clear("R4 cleared relay still open");
        step(1, 500, 300, 300, 1, 0, 0, "R4 relay still open");
        step(0, 0, 0, 0, 1, 1, 0, "R6 relay recloses");
        step(1, 720, 300, 300, 0, 1, 0, "R4 start_done with overvoltage");
        idle_clear("R9 clear");

        // R9: clear coinciding with set condition
        step(1, 800, 300, 300, 1, 0, 0, "R9 set");
        step(1, 800, 300, 300, 1, 0, 1, "R9 clear with condition present");
        step(1, 500, 300, 300, 1, 0, 1, "R9 clear with condition gone");
        step(1, 100, 300, 300, 0, 1, 1, "R9 clear with undervoltage present");
        idle_clear("R9 clear undervoltage");

        // R10: priorities
        step(1, 500, 100, 300, 1, 0, 0, "R10 imbalance alone");
        step(1, 100, 100, 300, 1, 1, 0, "R10 undervoltage over imbalance");
        step(1, 500, 410, 300, 1, 0, 0, "R10 module overvoltage over undervoltage");
        step(1, 760, 410, 300, 1, 0, 0, "R10 run over module");
        step(1, 710, 300, 300, 0, 0, 0, "R10 startup over run");
        idle_clear("R10 all latched cleared");

        // R11: ignored inputs without valid strobe
        step(1, 500, 100, 300, 1, 0, 0, "R11 imbalance set");
        step(0, 1000, 1000, 0, 0, 0, 0, "R11 invalid extreme values ignored");
        step(0, 1000, 0, 0, 1, 0, 0, "R11 invalid equal values ignored");

        // R12: reset while faults are active
        step(1, 800, 450, 0, 1, 0, 0, "R12 load faults");
        do_reset();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule